// File: doc/BRIEF.md
# Multi-mode interrupt request generator

This block sits between a command engine and the host-facing interrupt paths of an endpoint function. The command engine hands it one request at a time, made of an interrupt kind and an interrupt number taken from its own type and number registers. The same pair serves two cases: a direct "raise an interrupt" command, and the interrupt that follows a finished read, write or copy job. The block checks the number against the range that is legal for the chosen kind. It then drives exactly one interrupt and reports back with a one-cycle done pulse, which the engine uses to set its "interrupt raised" status bit. A request it cannot serve gives a one-cycle error pulse instead, and nothing is sent.

Three kinds exist. A level-type legacy line stays high until the host clears it. The two message kinds (MSI and MSI-X) are passed to a downstream message builder over a valid/ready handshake that carries a zero-based vector. The block does not build bus messages and holds no capability structures or vector tables.

Top module: `irq_dispatch`

## Requirements
- R1: The kind code on `irq_type` selects the path: 0 drives the legacy line, 1 sends a message with `msg_is_msix` = 0 (MSI), and 2 sends a message with `msg_is_msix` = 1 (MSI-X).
- R2: A legacy request is valid only with number 0. Any other number gives an error pulse and leaves the line low.
- R3: An MSI request is valid for numbers 1 to `MSI_MAX` (default 32) and sends `msg_vector` = number − 1. Numbers 0 and `MSI_MAX`+1 give an error pulse and send no message.
- R4: An MSI-X request is valid for numbers 1 to `MSIX_MAX` (default 2048) and sends `msg_vector` = number − 1. Numbers 0 and `MSIX_MAX`+1 give an error pulse and send no message.
- R5: A kind code of 3 or higher gives an error pulse and sends nothing: no line change and no message.
- R6: `done` is high for exactly one cycle. For legacy it comes in the cycle after the request is accepted; for a message it comes in the cycle after `msg_valid && msg_ready`. `err` is high for one cycle, in the cycle after an invalid request is accepted. `done` and `err` are never high together.
- R7: Once set, the legacy line stays high until `intx_clear` is sampled high. It then falls in the next cycle. If a legacy set and a clear arrive in the same cycle, the set wins.
- R8: A message request appears one cycle after the request is accepted. `msg_valid`, `msg_vector` and `msg_is_msix` stay stable until the cycle in which `msg_ready` is high. In the cycle after that, `msg_valid` is low.
- R9: While a message is pending, `req_ready` is low and `req_valid` is ignored. A request offered in that time has no effect after the message completes.
- R10: After a synchronous active-low reset, `intx_line`, `msg_valid`, `done` and `err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command engine offers an interrupt request |
| req_ready | output | 1 | Block can take a request this cycle |
| irq_type | input | TYPE_W | Interrupt kind code (0 legacy, 1 MSI, 2 MSI-X) |
| irq_num | input | NUM_W | Interrupt number for the request |
| done | output | 1 | One-cycle pulse: interrupt sent |
| err | output | 1 | One-cycle pulse: request rejected |
| intx_line | output | 1 | Level-type legacy interrupt line |
| intx_clear | input | 1 | Host clears the legacy line |
| msg_valid | output | 1 | Message interrupt request pending |
| msg_ready | input | 1 | Message builder accepts the request |
| msg_is_msix | output | 1 | 0 = MSI message, 1 = MSI-X message |
| msg_vector | output | VEC_W | Zero-based vector (number − 1) |

## Verification
The bench builds the block with its default parameters: a 4-bit kind code, a 12-bit number, `MSI_MAX` = 32 and `MSIX_MAX` = 2048. The 4-bit kind reaches codes 3 and 9, so the rejection of unused codes is tested. The 12-bit number can carry 2049, just past the MSI-X limit, as well as both range ends of each kind, so every edge is driven by a real input value. With an 11-bit vector, the MSI-X top vector 2047 uses the full output width.

// File: rtl/irqd_pkg.sv
// Package: shared types for the interrupt dispatcher.
// Assumes: the kind codes below are the only ones the checker produces.
package irqd_pkg;

    // Resolved request class after range checking
    typedef enum logic [1:0] {
        KIND_LEGACY = 2'd0,
        KIND_MSI    = 2'd1,
        KIND_MSIX   = 2'd2,
        KIND_BAD    = 2'd3
    } irq_kind_e;

endpackage

// File: rtl/irqd_check.sv
// Module: irqd_check
// Sorts an incoming kind code and number into legacy, MSI, MSI-X or bad.
// Assumes: MSI_MAX and MSIX_MAX both fit in NUM_W bits; purely combinational.
module irqd_check
    import irqd_pkg::*;
#(
    parameter int TYPE_W   = 4,
    parameter int NUM_W    = 12,
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048
) (
    input  logic [TYPE_W-1:0] irq_type,
    input  logic [NUM_W-1:0]  irq_num,
    output irq_kind_e         kind
);

    localparam logic [NUM_W-1:0]  MSI_LIM   = NUM_W'(MSI_MAX);
    localparam logic [NUM_W-1:0]  MSIX_LIM  = NUM_W'(MSIX_MAX);
    localparam logic [TYPE_W-1:0] CODE_LEG  = TYPE_W'(0);
    localparam logic [TYPE_W-1:0] CODE_MSI  = TYPE_W'(1);
    localparam logic [TYPE_W-1:0] CODE_MSIX = TYPE_W'(2);

    logic num_zero;

    // Purpose: zero detect shared by all three range checks
    always_comb num_zero = (irq_num == '0);

    // Purpose: classify the request by kind code and legal number range
    always_comb begin
        kind = KIND_BAD;
        if (irq_type == CODE_LEG) begin
            if (num_zero) kind = KIND_LEGACY;
        end else if (irq_type == CODE_MSI) begin
            if (!num_zero && irq_num <= MSI_LIM) kind = KIND_MSI;
        end else if (irq_type == CODE_MSIX) begin
            if (!num_zero && irq_num <= MSIX_LIM) kind = KIND_MSIX;
        end
    end

endmodule

// File: rtl/irqd_line.sv
// Module: irqd_line
// Level-type legacy interrupt line: set by a request, cleared by the host.
// Assumes: set has priority over clear in the same cycle.
module irqd_line (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clear,
    output logic line
);

    // Purpose: hold the line level between a set and a host clear
    always_ff @(posedge clk) begin
        if (!rst_n)     line <= 1'b0;
        else if (set)   line <= 1'b1;
        else if (clear) line <= 1'b0;
    end

    // R7: the line is not dropped without a clear
    assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line && !clear |=> line);

    // R7: a set always wins, even against a clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> line);

endmodule

// File: rtl/irqd_msg.sv
// Module: irqd_msg
// Holds one message interrupt request and offers it with valid/ready.
// Assumes: load is only raised while no request is pending.
module irqd_msg #(
    parameter int VEC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_msix,
    input  logic [VEC_W-1:0] load_vec,
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic             msg_is_msix,
    output logic [VEC_W-1:0] msg_vector,
    output logic             fire
);

    // Purpose: a transfer completes when the request is offered and taken
    always_comb fire = msg_valid && msg_ready;

    // Purpose: pending flag, set on load and dropped on transfer
    always_ff @(posedge clk) begin
        if (!rst_n)    msg_valid <= 1'b0;
        else if (load) msg_valid <= 1'b1;
        else if (fire) msg_valid <= 1'b0;
    end

    // Purpose: capture the payload only on load so it stays stable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_is_msix <= 1'b0;
            msg_vector  <= '0;
        end else if (load) begin
            msg_is_msix <= load_msix;
            msg_vector  <= load_vec;
        end
    end

    // R8: an offered request is held with its payload until accepted
    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_is_msix));

    // R8: a single transfer per request
    assert_msg_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !msg_valid);

endmodule

// File: rtl/irq_dispatch.sv
// Module: irq_dispatch (top)
// Takes one interrupt request at a time from a command engine, checks it,
// then raises the legacy line or offers an MSI / MSI-X message. It answers
// with a done or an error pulse.
// Assumes: MSI_MAX <= MSIX_MAX, NUM_W >= VEC_W, TYPE_W >= 2.
module irq_dispatch
    import irqd_pkg::*;
#(
    parameter int TYPE_W   = 4,
    parameter int NUM_W    = 12,
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048,
    localparam int VEC_W   = $clog2(MSIX_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic [NUM_W-1:0]  irq_num,
    output logic              done,
    output logic              err,
    output logic              intx_line,
    input  logic              intx_clear,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              msg_is_msix,
    output logic [VEC_W-1:0]  msg_vector
);

    irq_kind_e        kind;
    logic             accept;
    logic             set_line;
    logic             load_msg;
    logic             fire;
    logic [VEC_W-1:0] vec_m1;

    // Purpose: range check of the offered request
    irqd_check #(
        .TYPE_W  (TYPE_W),
        .NUM_W   (NUM_W),
        .MSI_MAX (MSI_MAX),
        .MSIX_MAX(MSIX_MAX)
    ) u_check (
        .irq_type(irq_type),
        .irq_num (irq_num),
        .kind    (kind)
    );

    // Purpose: accept only while no message is waiting for the builder
    always_comb begin
        req_ready = !msg_valid;
        accept    = req_valid && req_ready;
        set_line  = accept && (kind == KIND_LEGACY);
        load_msg  = accept && (kind == KIND_MSI || kind == KIND_MSIX);
        vec_m1    = VEC_W'(irq_num - NUM_W'(1));
    end

    // Purpose: legacy level line
    irqd_line u_line (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_line),
        .clear(intx_clear),
        .line (intx_line)
    );

    // Purpose: message request holder with handshake
    irqd_msg #(
        .VEC_W(VEC_W)
    ) u_msg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_msg),
        .load_msix  (kind == KIND_MSIX),
        .load_vec   (vec_m1),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_is_msix(msg_is_msix),
        .msg_vector (msg_vector),
        .fire       (fire)
    );

    // Purpose: one-cycle completion and rejection pulses to the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= set_line || fire;
            err  <= accept && (kind == KIND_BAD);
        end
    end

    // R6: never report success and failure together
    assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R6: a finished message transfer is reported next cycle
    assert_done_after_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> done);

    // R9: nothing completes while a message waits
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> !done && !err);

    // R5: a rejected request has no message outstanding
    assert_err_no_msg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !msg_valid);

    // R3: an MSI vector stays inside the MSI range
    assert_msi_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_is_msix |-> msg_vector < VEC_W'(MSI_MAX));

endmodule

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;

    localparam int TYPE_W = 4;
    localparam int NUM_W  = 12;
    localparam int VEC_W  = 11;

    // Entry: {kind code, number, expected class, expected vector}
    // class: 0 legacy, 1 MSI, 2 MSI-X, 3 rejected
    localparam int NV = 13;
    localparam logic [28:0] TBL [NV] = '{
        {4'd0, 12'd0,    2'd0, 11'd0},
        {4'd0, 12'd1,    2'd3, 11'd0},
        {4'd1, 12'd0,    2'd3, 11'd0},
        {4'd1, 12'd1,    2'd1, 11'd0},
        {4'd1, 12'd32,   2'd1, 11'd31},
        {4'd1, 12'd33,   2'd3, 11'd0},
        {4'd2, 12'd0,    2'd3, 11'd0},
        {4'd2, 12'd1,    2'd2, 11'd0},
        {4'd2, 12'd2048, 2'd2, 11'd2047},
        {4'd2, 12'd2049, 2'd3, 11'd0},
        {4'd3, 12'd1,    2'd3, 11'd0},
        {4'd9, 12'd0,    2'd3, 11'd0},
        {4'd2, 12'd777,  2'd2, 11'd776}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [TYPE_W-1:0] irq_type = '0;
    logic [NUM_W-1:0]  irq_num = '0;
    logic              done, err, intx_line;
    logic              intx_clear = 1'b0;
    logic              msg_valid;
    logic              msg_ready = 1'b0;
    logic              msg_is_msix;
    logic [VEC_W-1:0]  msg_vector;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_dispatch u_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .irq_type(irq_type), .irq_num(irq_num), .done(done), .err(err),
        .intx_line(intx_line), .intx_clear(intx_clear), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_is_msix(msg_is_msix), .msg_vector(msg_vector)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_line();
        @(negedge clk) intx_clear = 1'b1;
        @(negedge clk) intx_clear = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: state during and right after reset
        chk("R10", "line", intx_line, 0);
        chk("R10", "msg_valid", msg_valid, 0);
        chk("R10", "done", done, 0);
        chk("R10", "err", err, 0);
        chk("R10", "req_ready", req_ready, 1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [TYPE_W-1:0] t;
            logic [NUM_W-1:0]  n;
            logic [1:0]        k;
            logic [VEC_W-1:0]  v;
            string             tag;
            {t, n, k, v} = TBL[i];
            if (k == 2'd0)      tag = "R1";
            else if (k == 2'd1) tag = "R3";
            else if (k == 2'd2) tag = "R4";
            else if (t >= 3)    tag = "R5";
            else if (t == 0)    tag = "R2";
            else if (t == 1)    tag = "R3";
            else                tag = "R4";
            clear_line();
            @(negedge clk);
            req_valid = 1'b1; irq_type = t; irq_num = n;
            @(negedge clk);
            req_valid = 1'b0;
            if (k == 2'd3) begin
                chk(tag, "err", err, 1);
                chk(tag, "done", done, 0);
                chk(tag, "line", intx_line, 0);
                chk(tag, "msg_valid", msg_valid, 0);
            end else if (k == 2'd0) begin
                chk("R6", "done legacy", done, 1);
                chk("R1", "line", intx_line, 1);
                chk("R1", "msg_valid", msg_valid, 0);
                @(negedge clk);
                chk("R6", "done width", done, 0);
                chk("R7", "line held", intx_line, 1);
            end else begin
                chk(tag, "msg_valid", msg_valid, 1);
                chk(tag, "vector", msg_vector, v);
                chk("R1", "is_msix", msg_is_msix, (k == 2'd2));
                chk("R6", "done early", done, 0);
                // R9: offer a legacy request while the message waits
                req_valid = 1'b1; irq_type = '0; irq_num = '0;
                @(negedge clk);
                req_valid = 1'b0;
                chk("R9", "req_ready", req_ready, 0);
                chk("R8", "valid held", msg_valid, 1);
                chk("R8", "vector held", msg_vector, v);
                msg_ready = 1'b1;
                @(negedge clk);
                msg_ready = 1'b0;
                chk("R6", "done msg", done, 1);
                chk("R8", "valid drop", msg_valid, 0);
                chk("R9", "ignored legacy", intx_line, 0);
                @(negedge clk);
                chk("R6", "done width", done, 0);
            end
        end

        // R7: host clear drops the line one cycle later
        clear_line();
        chk("R7", "clear", intx_line, 0);
        // R7: set wins over a clear in the same cycle
        @(negedge clk);
        req_valid = 1'b1; irq_type = '0; irq_num = '0; intx_clear = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; intx_clear = 1'b0;
        chk("R7", "set wins", intx_line, 1);
        // R10: reset drops a raised line and a pending message
        @(negedge clk);
        req_valid = 1'b1; irq_type = 4'd1; irq_num = 12'd5;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "msg before reset", msg_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "line after reset", intx_line, 0);
        chk("R10", "msg after reset", msg_valid, 0);
        chk("R10", "ready after reset", req_ready, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule